// File: doc/BRIEF.md
# Nibble-Stepped Multiply-Accumulate Multiplier

This block forms the full 16-bit unsigned product of two 8-bit operands by running one narrow multiply-add cell four times. The cell takes two 4-bit factors and two 4-bit addends, and returns `x*y + c + s` as 8 bits. The largest value it can produce is 15*15 + 15 + 15 = 255, so it never overflows. The cell can be built as a row-by-row ripple-carry array or as a carry-save array with a single final adder. A parameter adds one register stage at the cell output.

A sequencer steps the cell through four passes. Each pass multiplies one nibble pair. The carries and the shifted sum bits from earlier passes are fed back through the two addend inputs:

- **PASS0**: `AL*BL`.
- **PASS1**: `AH*BL + hi(PASS0)`.
- **PASS2**: `AL*BH + lo(PASS1)`.
- **PASS3**: `AH*BH + hi(PASS1) + hi(PASS2)`.

The product nibbles are, from the least significant upward: `lo(PASS0)`, `lo(PASS2)`, then the whole of PASS3.

The state machine has the states IDLE, PASS0, PASS1, PASS2, PASS3 and DRAIN. DRAIN exists only in the pipelined build. Its transitions are:

- **accept**: IDLE to PASS0, when start is seen in IDLE.
- **step**: PASS0 to PASS1, PASS1 to PASS2, and PASS2 to PASS3, one per cycle.
- **finish**: PASS3 to IDLE in the combinational build.
- **flush**: PASS3 to DRAIN, then DRAIN to IDLE, in the pipelined build.

The result is registered together with a one-cycle done pulse on the finish or flush transition.

Top module: `nibble_mac_mul`

## Requirements
- R1: When `done_o` is high, `prod_o` equals the unsigned product of the `op_a_i` and `op_b_i` values sampled with the accepted start.
- R2: `done_o` is high for exactly one cycle per accepted start.
- R3: `done_o` rises in the cycle that follows the 4th rising edge after the accepting edge when `PIPE_EN=0`, and after the 5th when `PIPE_EN=1`.
- R4: A start seen while the block is busy is ignored. It changes neither the result nor the timing, and it produces no extra done pulse.
- R5: `prod_o` keeps its last value until the next completion.
- R6: While `rst_n` is low, `prod_o` is 0 and `done_o` is 0. Reset abandons any operation in flight, and that operation produces no done pulse afterwards.
- R7: Full-range operands (for example 0xFF*0xFF = 0xFE01) give exact results, with carries passed through both addend inputs.
- R8: The ripple-carry and carry-save cell variants produce identical products.
- R9: A start given in the cycle `done_o` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a multiply; operands sampled with it |
| op_a_i | input | 8 | Unsigned multiplicand |
| op_b_i | input | 8 | Unsigned multiplier |
| prod_o | output | 16 | Unsigned product, held between completions |
| done_o | output | 1 | One-cycle pulse when `prod_o` is fresh |

## Verification
The bench builds two copies side by side. One is combinational with the ripple-carry cell. The other is pipelined with the carry-save cell. Both receive the same stimulus, so both latencies and both array organisations are observed together, and their products can be compared with each other.

Because the two copies differ in latency, some starts fall inside the pipelined copy's DRAIN cycle. The combinational copy is already idle at that point and accepts them. This makes the busy-ignore rule and the back-to-back acceptance rule visible in one sequence.

// File: rtl/nmac_pkg.sv
package nmac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PASS0 = 3'd1,
        ST_PASS1 = 3'd2,
        ST_PASS2 = 3'd3,
        ST_PASS3 = 3'd4,
        ST_DRAIN = 3'd5
    } seq_state_t;

    localparam int PASS_COUNT = 4;

endpackage

// File: rtl/nmac_cell.sv
module nmac_cell #(
    parameter int AW   = 4,
    parameter int BW   = 4,
    parameter int CW   = 4,
    parameter bit PIPE = 1'b0,
    parameter bit CSA  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    x_i,
    input  logic [BW-1:0]    y_i,
    input  logic [CW-1:0]    c_i,
    input  logic [CW-1:0]    s_i,
    output logic [AW+BW-1:0] r_o
);

    localparam int RW = AW + BW;

    logic [RW-1:0] pp    [BW];
    logic [RW-1:0] c_ext;
    logic [RW-1:0] s_ext;
    logic [RW-1:0] sum_w;

    assign c_ext = {{(RW-CW){1'b0}}, c_i};
    assign s_ext = {{(RW-CW){1'b0}}, s_i};

    // one partial-product row per multiplier bit
    for (genvar i = 0; i < BW; i++) begin : g_pp
        assign pp[i] = y_i[i] ? ({{BW{1'b0}}, x_i} << i) : '0;
    end

    if (CSA) begin : g_csa
        logic [RW-1:0] sv [BW+1];
        logic [RW-1:0] cv [BW+1];
        assign sv[0] = c_ext;
        assign cv[0] = s_ext;
        // 3:2 compression of each row, carries kept apart
        for (genvar i = 0; i < BW; i++) begin : g_row
            assign sv[i+1] = sv[i] ^ cv[i] ^ pp[i];
            assign cv[i+1] = ((sv[i] & cv[i]) | (sv[i] & pp[i]) | (cv[i] & pp[i])) << 1;
        end
        assign sum_w = sv[BW] + cv[BW];
    end else begin : g_rca
        logic [RW-1:0] acc [BW+1];
        assign acc[0] = c_ext + s_ext;
        // each row resolves its carries before the next
        for (genvar i = 0; i < BW; i++) begin : g_row
            assign acc[i+1] = acc[i] + pp[i];
        end
        assign sum_w = acc[BW];
    end

    if (PIPE) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_o <= '0;
            else        r_o <= sum_w;
        end
    end else begin : g_comb
        assign r_o = sum_w;
    end

endmodule

// File: rtl/nmac_seq.sv
module nmac_seq
    import nmac_pkg::*;
#(
    parameter int NW   = 4,
    parameter bit PIPE = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [2*NW-1:0] op_a_i,
    input  logic [2*NW-1:0] op_b_i,
    output logic            busy_o,
    output logic [NW-1:0]   cx_o,
    output logic [NW-1:0]   cy_o,
    output logic [NW-1:0]   cc_o,
    output logic [NW-1:0]   cs_o,
    input  logic [2*NW-1:0] cr_i,
    output logic [4*NW-1:0] prod_o,
    output logic            done_o
);

    localparam seq_state_t LAST_ST = PIPE ? ST_DRAIN : ST_PASS3;

    seq_state_t      state_q, state_d;
    logic [2*NW-1:0] a_q, b_q;
    logic [2*NW-1:0] lo_q;
    logic [NW-1:0]   hold_q;
    logic [2*NW-1:0] prev;
    logic [NW-1:0]   mid_nib;
    logic            accept;

    assign busy_o = (state_q != ST_IDLE);
    assign accept = start_i && !busy_o;

    // result of the previous pass, one cycle after it was issued
    if (PIPE) begin : g_prev_core
        assign prev = cr_i;
    end else begin : g_prev_reg
        logic [2*NW-1:0] res_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= cr_i;
        end
        assign prev = res_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_PASS0;
            ST_PASS0: state_d = ST_PASS1;
            ST_PASS1: state_d = ST_PASS2;
            ST_PASS2: state_d = ST_PASS3;
            ST_PASS3: state_d = PIPE ? ST_DRAIN : ST_IDLE;
            ST_DRAIN: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // operand steering for the multiply-add cell
    always_comb begin
        cx_o = '0;
        cy_o = '0;
        cc_o = '0;
        cs_o = '0;
        unique case (state_q)
            ST_PASS0: begin
                cx_o = a_q[NW-1:0];
                cy_o = b_q[NW-1:0];
            end
            ST_PASS1: begin
                cx_o = a_q[2*NW-1:NW];
                cy_o = b_q[NW-1:0];
                cc_o = prev[2*NW-1:NW];
            end
            ST_PASS2: begin
                cx_o = a_q[NW-1:0];
                cy_o = b_q[2*NW-1:NW];
                cc_o = prev[NW-1:0];
            end
            ST_PASS3: begin
                cx_o = a_q[2*NW-1:NW];
                cy_o = b_q[2*NW-1:NW];
                cc_o = hold_q;
                cs_o = prev[2*NW-1:NW];
            end
            default: ;
        endcase
    end

    assign mid_nib = PIPE ? lo_q[2*NW-1:NW] : prev[NW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            lo_q   <= '0;
            hold_q <= '0;
            prod_o <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (accept) begin
                a_q <= op_a_i;
                b_q <= op_b_i;
            end
            if (state_q == ST_PASS1) lo_q[NW-1:0]      <= prev[NW-1:0];
            if (state_q == ST_PASS2) hold_q            <= prev[2*NW-1:NW];
            if (state_q == ST_PASS3) lo_q[2*NW-1:NW]   <= prev[NW-1:0];
            if (state_q == LAST_ST) begin
                prod_o <= {cr_i, mid_nib, lo_q[NW-1:0]};
                done_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/nibble_mac_mul.sv
module nibble_mac_mul #(
    parameter int NIB_W      = 4,
    parameter bit PIPE_EN    = 1'b0,
    parameter bit CARRY_SAVE = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [2*NIB_W-1:0] op_a_i,
    input  logic [2*NIB_W-1:0] op_b_i,
    output logic [4*NIB_W-1:0] prod_o,
    output logic               done_o
);

    localparam int OP_W    = 2 * NIB_W;
    localparam int LAT_CYC = nmac_pkg::PASS_COUNT + (PIPE_EN ? 1 : 0);

    logic [NIB_W-1:0] cx_w, cy_w, cc_w, cs_w;
    logic [OP_W-1:0]  cr_w;
    logic             busy_w;

    nmac_seq #(
        .NW   (NIB_W),
        .PIPE (PIPE_EN)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .op_a_i  (op_a_i),
        .op_b_i  (op_b_i),
        .busy_o  (busy_w),
        .cx_o    (cx_w),
        .cy_o    (cy_w),
        .cc_o    (cc_w),
        .cs_o    (cs_w),
        .cr_i    (cr_w),
        .prod_o  (prod_o),
        .done_o  (done_o)
    );

    nmac_cell #(
        .AW   (NIB_W),
        .BW   (NIB_W),
        .CW   (NIB_W),
        .PIPE (PIPE_EN),
        .CSA  (CARRY_SAVE)
    ) u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .x_i   (cx_w),
        .y_i   (cy_w),
        .c_i   (cc_w),
        .s_i   (cs_w),
        .r_o   (cr_w)
    );

endmodule

// File: rtl/nmac_mul_chk.sv
module nmac_mul_chk #(
    parameter int OP_W    = 8,
    parameter int DONE_AT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic [OP_W-1:0]   op_a,
    input logic [OP_W-1:0]   op_b,
    input logic [2*OP_W-1:0] prod,
    input logic              done
);

    localparam int CNT_W  = $clog2(DONE_AT + 2) + 1;
    localparam int TARGET = DONE_AT + 1;

    logic              accept;
    logic [2*OP_W-1:0] exp_q;
    logic [CNT_W-1:0]  cnt_q;

    assign accept = start && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_q <= '0;
            cnt_q <= '0;
        end else begin
            if (accept) begin
                exp_q <= op_a * op_b;
                cnt_q <= CNT_W'(1);
            end else if (cnt_q == CNT_W'(TARGET)) begin
                cnt_q <= '0;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R1
    prod_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> prod == exp_q);

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    done_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done == (cnt_q == CNT_W'(TARGET)));

    // R4
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

    // R5
    prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(prod));

endmodule

bind nibble_mac_mul nmac_mul_chk #(
    .OP_W    (OP_W),
    .DONE_AT (LAT_CYC)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_i),
    .busy  (busy_w),
    .op_a  (op_a_i),
    .op_b  (op_b_i),
    .prod  (prod_o),
    .done  (done_o)
);

// File: tb/sim_nibble_mac_mul.sv
module sim_nibble_mac_mul;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  op_a = '0;
    logic [7:0]  op_b = '0;
    logic [15:0] prod0, prod1;
    logic        done0, done1;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    nibble_mac_mul #(.NIB_W(4), .PIPE_EN(1'b0), .CARRY_SAVE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_a_i(op_a),
        .op_b_i(op_b), .prod_o(prod0), .done_o(done0));

    nibble_mac_mul #(.NIB_W(4), .PIPE_EN(1'b1), .CARRY_SAVE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_a_i(op_a),
        .op_b_i(op_b), .prod_o(prod1), .done_o(done1));

    // {a, b, expected product}
    localparam logic [31:0] VEC [12] = '{
        {8'h00, 8'h00, 16'h0000},
        {8'hFF, 8'hFF, 16'hFE01},
        {8'h01, 8'hFF, 16'h00FF},
        {8'h0F, 8'h0F, 16'h00E1},
        {8'hF0, 8'hF0, 16'hE100},
        {8'h10, 8'h10, 16'h0100},
        {8'h80, 8'h02, 16'h0100},
        {8'hAB, 8'hCD, 16'h88EF},
        {8'h12, 8'h34, 16'h03A8},
        {8'hF0, 8'h0F, 16'h0E10},
        {8'h7F, 8'h81, 16'h3FFF},
        {8'h5A, 8'hA5, 16'h3A02}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // start at negedge N0; u0 done at N5, u1 done at N6
    task automatic run_pair(input logic [7:0] a, input logic [7:0] b,
                            input logic [15:0] e);
        @(negedge clk);
        start = 1'b1; op_a = a; op_b = b;
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk);
            if (k == 1) begin start = 1'b0; op_a = ~a; op_b = ~b; end
            chk(done0 == (k == 5), "R3 R2 done timing comb", done0, (k == 5));
            chk(done1 == (k == 6), "R3 R2 done timing pipe", done1, (k == 6));
            if (k == 5) chk(prod0 == e, "R1 R7 product comb", prod0, e);
            if (k == 6) begin
                chk(prod1 == e, "R1 R7 product pipe", prod1, e);
                chk(prod0 == prod1, "R8 variants agree", prod1, prod0);
            end
            if (k == 7) begin
                chk(prod0 == e, "R5 hold comb", prod0, e);
                chk(prod1 == e, "R5 hold pipe", prod1, e);
            end
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R6 reset state
        chk(prod0 == 16'h0 && !done0, "R6 reset comb", {done0, prod0}, 0);
        chk(prod1 == 16'h0 && !done1, "R6 reset pipe", {done1, prod1}, 0);
        rst_n = 1'b1;

        for (int i = 0; i < 12; i++)
            run_pair(VEC[i][31:24], VEC[i][23:16], VEC[i][15:0]);

        // R4: second start while busy at N2 must be ignored
        @(negedge clk);
        start = 1'b1; op_a = 8'h3C; op_b = 8'h55;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            start = (k == 2);
            op_a  = (k == 2) ? 8'hFF : 8'h00;
            op_b  = (k == 2) ? 8'hFF : 8'h00;
            chk(done0 == (k == 5), "R4 no extra done comb", done0, (k == 5));
            chk(done1 == (k == 6), "R4 no extra done pipe", done1, (k == 6));
            if (k == 5) chk(prod0 == 16'h13EC, "R4 result comb", prod0, 16'h13EC);
            if (k == 6) chk(prod1 == 16'h13EC, "R4 result pipe", prod1, 16'h13EC);
        end

        // R9: start in u0 done cycle (N5) accepted; u1 still in DRAIN ignores it
        @(negedge clk);
        start = 1'b1; op_a = 8'h21; op_b = 8'h43;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            start = (k == 5);
            op_a  = (k == 5) ? 8'hC8 : 8'h00;
            op_b  = (k == 5) ? 8'h0B : 8'h00;
            chk(done0 == (k == 5 || k == 10), "R9 done comb", done0, (k == 5 || k == 10));
            chk(done1 == (k == 6), "R4 R9 done pipe", done1, (k == 6));
            if (k == 5)  chk(prod0 == 16'h08A3, "R9 first comb", prod0, 16'h08A3);
            if (k == 10) chk(prod0 == 16'h0898, "R9 second comb", prod0, 16'h0898);
            if (k == 12) chk(prod1 == 16'h08A3, "R4 pipe kept", prod1, 16'h08A3);
        end

        // R6: reset in flight abandons the operation
        @(negedge clk);
        start = 1'b1; op_a = 8'h99; op_b = 8'h77;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(prod0 == 16'h0 && !done0, "R6 reset mid comb", {done0, prod0}, 0);
        chk(prod1 == 16'h0 && !done1, "R6 reset mid pipe", {done1, prod1}, 0);
        rst_n = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            chk(!done0 && !done1, "R6 no done after reset", {done0, done1}, 0);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule